// File: doc/BRIEF.md
# SD Host Block Write Engine

This block is the host-side transmit data path for writing to an SD-style card. Software programs a total byte count, a block size in bytes, a bus width (one or four data lines) and a busy timeout, then pulses `start`. The engine splits the byte count into fixed-size blocks. For each block it drives a start slot, the payload, a CRC16 per active line and an end slot. It then releases the lines, reads the card's three-bit acceptance token on DAT0 and waits while the card holds DAT0 low. Only then does it send the next block.

Payload bytes arrive on a valid/ready byte stream. One bit slot lasts one clock cycle, because the card clock divider sits outside this block. When the byte count does not fill the last block, the engine pads that block with zero bytes and does not draw them from the stream. The transfer ends in one of three held status flags: done, token error or busy timeout.

Top module: `sdwr_engine`

## Requirements
- R1: After reset, `dat_oe` is 0, `s_ready`, `active`, `done`, `crc_err` and `to_err` are all 0.
- R2: Each block opens with one slot in which every active line is driven 0. `dat_oe` is 4'b0001 when `wide`=0 and 4'b1111 when `wide`=1. The first block's start slot is the cycle after `start` is sampled with a nonzero length.
- R3: Payload order. With `wide`=0, each byte goes out MSB first on line 0. With `wide`=1, each byte takes two slots: the high nibble, then the low nibble, with nibble bit 3 on line 3 and bit 0 on line 0.
- R4: The 16 slots after the payload carry, on each active line, the CRC16 of that line's payload bits, MSB first. The CRC uses polynomial 0x1021 and an initial value of 0.
- R5: After the CRC comes one slot with every active line driven 1. In the following cycle all lines are released (`dat_oe`=0).
- R6: DAT0 is sampled 2, 3 and 4 cycles after the end slot, first bit as MSB. Token 3'b010 accepts the block. Any other value sets `crc_err`, ends the transfer (`active`=0) and takes no more stream bytes.
- R7: From 5 cycles after the end slot, the engine keeps all lines released while DAT0 is low. The next block's start slot is the cycle after DAT0 is sampled high.
- R8: If DAT0 stays low for `busy_limit` consecutive busy cycles (`busy_limit` ≥ 1), `to_err` is set and `active` drops.
- R9: The engine sends ceil(`total_len`/`blk_size`) blocks of exactly `blk_size` bytes. The bytes after `total_len` are 0x00, and exactly `total_len` bytes are taken from the stream.
- R10: `done` is set and `active` cleared in the cycle after DAT0 is sampled high following the last block. With `total_len`=0, `done` is set the cycle after `start`, and the lines are never driven.
- R11: `done`, `crc_err` and `to_err` hold until the next accepted `start`, which clears them. At most one of them is high.
- R12: A byte is taken only on a cycle with `s_valid` and `s_ready` both high. `s_ready` is never high while `active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus bit slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| total_len | input | LEN_W | Bytes to send |
| blk_size | input | BLK_W | Block size in bytes, at least 1 |
| wide | input | 1 | 1: four data lines, 0: one line |
| busy_limit | input | TO_W | Busy timeout in cycles, at least 1 |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Engine takes the stream byte |
| dat0_in | input | 1 | Sampled level of data line 0 |
| dat_out | output | 4 | Data line drive values |
| dat_oe | output | 4 | Data line drive enables |
| active | output | 1 | A transfer is in progress |
| done | output | 1 | Transfer completed |
| crc_err | output | 1 | Card rejected a block |
| to_err | output | 1 | Busy wait timed out |

## Verification
The hardest situations to reach from the ports are the decisions made after a block's bits: a rejected token on a block other than the first, and a busy period that ends exactly one cycle before the timeout or exactly at it. The bench acts as the card, cycle by cycle. It counts slots from the end bit and drives the token, the busy low time and the release at chosen offsets. It mixes seeded random lengths, block sizes, widths and busy times with directed cases that put a bad token on a chosen block, set the busy time at and just under the limit, and use lengths that leave a padded last block.

// File: rtl/sdwr_pkg.sv
package sdwr_pkg;
    localparam int NLINES = 4;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [2:0] TOK_OK = 3'b010;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_CRC, S_END, S_STAT, S_BUSY
    } st_e;
endpackage

// File: rtl/sdwr_crc_lane.sv
module sdwr_crc_lane
    import sdwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc
);
    logic [15:0] crc_d, crc_q;
    logic        fb;

    always_comb begin
        crc_d = crc_q;
        fb    = crc_q[15] ^ din;
        if (clr) begin
            crc_d = '0;
        end else if (en) begin
            crc_d = {crc_q[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/sdwr_busy_timer.sv
module sdwr_busy_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        expired = tick && (cnt_inc >= {1'b0, limit});
        cnt_d   = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = cnt_inc[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sdwr_engine.sv
module sdwr_engine
    import sdwr_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int BLK_W = 12,
    parameter int TO_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] total_len,
    input  logic [BLK_W-1:0] blk_size,
    input  logic             wide,
    input  logic [TO_W-1:0]  busy_limit,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    output logic             s_ready,
    input  logic             dat0_in,
    output logic [3:0]       dat_out,
    output logic [3:0]       dat_oe,
    output logic             active,
    output logic             done,
    output logic             crc_err,
    output logic             to_err
);
    typedef struct packed {
        st_e              st;
        logic             wide;
        logic [BLK_W-1:0] blk;
        logic [TO_W-1:0]  lim;
        logic [LEN_W-1:0] left;
        logic [BLK_W-1:0] nbyte;
        logic [7:0]       sh;
        logic [2:0]       slot;
        logic [3:0]       cnt;
        logic [2:0]       tok;
        logic             done;
        logic             cerr;
        logic             terr;
    } regs_t;

    regs_t r_d, r_q;

    logic              crc_clr, crc_en;
    logic              tmr_clr, tmr_tick, tmr_exp;
    logic [NLINES-1:0] lane_bit;
    logic [15:0]       crc_w [NLINES];
    logic              last_slot, last_byte, want, adv;
    logic [3:0]        oe_act;

    // one CRC unit per data line
    for (genvar g = 0; g < NLINES; g++) begin : g_lane
        sdwr_crc_lane u_crc (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (crc_clr),
            .en   (crc_en),
            .din  (lane_bit[g]),
            .crc  (crc_w[g])
        );
    end

    sdwr_busy_timer #(.W(TO_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .tick   (tmr_tick),
        .limit  (r_q.lim),
        .expired(tmr_exp)
    );

    always_comb begin
        lane_bit  = r_q.wide ? r_q.sh[7:4] : {3'b000, r_q.sh[7]};
        last_slot = r_q.wide ? (r_q.slot == 3'd1) : (r_q.slot == 3'd7);
        last_byte = (r_q.nbyte == r_q.blk - 1'b1);
        want      = last_slot && !last_byte && (r_q.left != '0);
        adv       = !want || s_valid;
    end

    // next-state logic
    always_comb begin
        r_d      = r_q;
        s_ready  = 1'b0;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        tmr_clr  = 1'b0;
        tmr_tick = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.wide = wide;
                    r_d.blk  = blk_size;
                    r_d.lim  = busy_limit;
                    r_d.left = total_len;
                    r_d.done = 1'b0;
                    r_d.cerr = 1'b0;
                    r_d.terr = 1'b0;
                    if (total_len == '0) r_d.done = 1'b1;
                    else                 r_d.st   = S_START;
                end
            end
            S_START: begin
                crc_clr = 1'b1;
                s_ready = 1'b1;
                if (s_valid) begin
                    r_d.sh    = s_data;
                    r_d.left  = r_q.left - 1'b1;
                    r_d.nbyte = '0;
                    r_d.slot  = '0;
                    r_d.st    = S_DATA;
                end
            end
            S_DATA: begin
                s_ready = want;
                if (adv) begin
                    crc_en   = 1'b1;
                    r_d.slot = last_slot ? 3'd0 : r_q.slot + 3'd1;
                    r_d.sh   = r_q.wide ? {r_q.sh[3:0], 4'h0} : {r_q.sh[6:0], 1'b0};
                    if (last_slot) begin
                        if (last_byte) begin
                            r_d.st  = S_CRC;
                            r_d.cnt = '0;
                        end else begin
                            r_d.nbyte = r_q.nbyte + 1'b1;
                            if (r_q.left != '0) begin
                                r_d.sh   = s_data;
                                r_d.left = r_q.left - 1'b1;
                            end else begin
                                r_d.sh = 8'h00;
                            end
                        end
                    end
                end
            end
            S_CRC: begin
                r_d.cnt = r_q.cnt + 4'd1;
                if (r_q.cnt == 4'd15) r_d.st = S_END;
            end
            S_END: begin
                r_d.st  = S_STAT;
                r_d.cnt = '0;
            end
            S_STAT: begin
                r_d.cnt = r_q.cnt + 4'd1;
                if (r_q.cnt >= 4'd1 && r_q.cnt <= 4'd3) r_d.tok = {r_q.tok[1:0], dat0_in};
                if (r_q.cnt == 4'd4) begin
                    if (r_q.tok == TOK_OK) begin
                        r_d.st  = S_BUSY;
                        tmr_clr = 1'b1;
                    end else begin
                        r_d.cerr = 1'b1;
                        r_d.st   = S_IDLE;
                    end
                end
            end
            S_BUSY: begin
                if (dat0_in) begin
                    tmr_clr = 1'b1;
                    if (r_q.left == '0) begin
                        r_d.done = 1'b1;
                        r_d.st   = S_IDLE;
                    end else begin
                        r_d.st = S_START;
                    end
                end else begin
                    tmr_tick = 1'b1;
                    if (tmr_exp) begin
                        r_d.terr = 1'b1;
                        r_d.st   = S_IDLE;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // line drive
    always_comb begin
        oe_act  = r_q.wide ? 4'hF : 4'h1;
        dat_oe  = 4'h0;
        dat_out = 4'hF;
        unique case (r_q.st)
            S_START: begin
                dat_oe  = oe_act;
                dat_out = 4'h0;
            end
            S_DATA: begin
                dat_oe  = oe_act;
                dat_out = r_q.wide ? r_q.sh[7:4] : {3'b111, r_q.sh[7]};
            end
            S_CRC: begin
                dat_oe = oe_act;
                for (int i = 0; i < NLINES; i++) begin
                    if (oe_act[i]) dat_out[i] = crc_w[i][4'd15 - r_q.cnt];
                end
            end
            S_END: dat_oe = oe_act;
            default: ;
        endcase
    end

    assign active  = (r_q.st != S_IDLE);
    assign done    = r_q.done;
    assign crc_err = r_q.cerr;
    assign to_err  = r_q.terr;
endmodule

// File: rtl/sdwr_engine_chk.sv
module sdwr_engine_chk
    import sdwr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       active,
    input logic       s_ready,
    input logic       dat0_in,
    input logic [3:0] dat_oe,
    input logic       done,
    input logic       crc_err,
    input logic       to_err,
    input st_e        st
);
    a_r12_no_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !s_ready);

    a_r2_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_oe == 4'h0) || (dat_oe == 4'h1) || (dat_oe == 4'hF));

    a_r11_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, crc_err, to_err}));

    a_r11_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active) |=> (!crc_err && !to_err));

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!active && dat_oe == 4'h0));

    a_r7_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BUSY && !dat0_in) |=> (st != S_START));

    a_r8_timeout_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_err) |-> $past(st == S_BUSY && !dat0_in));

    a_r6_token_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> ($past(st == S_STAT) && !active));
endmodule

bind sdwr_engine sdwr_engine_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .active (active),
    .s_ready(s_ready),
    .dat0_in(dat0_in),
    .dat_oe (dat_oe),
    .done   (done),
    .crc_err(crc_err),
    .to_err (to_err),
    .st     (r_q.st)
);

// File: tb/sim_sdwr_engine.sv
`timescale 1ns/1ps
module sim_sdwr_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] total_len = '0;
    logic [11:0] blk_size = 12'd1;
    logic        wide = 1'b0;
    logic [15:0] busy_limit = 16'd1;
    logic        s_valid;
    logic [7:0]  s_data;
    logic        s_ready;
    logic        dat0_in = 1'b1;
    logic [3:0]  dat_out, dat_oe;
    logic        active, done, crc_err, to_err;

    logic [7:0]  mem [64];
    int          sidx = 0;
    int          base = 0;
    int          cur_len = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    assign s_valid = (sidx - base) < cur_len;
    assign s_data  = mem[6'(sidx - base)];

    always @(posedge clk) if (s_valid && s_ready) sidx <= sidx + 1;

    sdwr_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
        .blk_size(blk_size), .wide(wide), .busy_limit(busy_limit),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .dat0_in(dat0_in), .dat_out(dat_out), .dat_oe(dat_oe),
        .active(active), .done(done), .crc_err(crc_err), .to_err(to_err)
    );

    function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Bench plays the card; token value tk is used on block tb_blk.
    task automatic xfer(input int len, input int bsz, input bit w, input int lim,
                        input logic [2:0] tk, input int tb_blk, input int busy_n);
        int nblk;
        logic [3:0] oe_exp;
        logic [15:0] crc_m [4];
        logic [2:0] t;
        bit bad;
        int act_v, exp_v;
        @(negedge clk);
        for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
        base = sidx;
        cur_len = len;
        total_len = 16'(len);
        blk_size = 12'(bsz);
        wide = w;
        busy_limit = 16'(lim);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!crc_err && !to_err, "R11 flags cleared by start", {crc_err, to_err}, 0);
        if (len == 0) begin
            chk(done && !active && dat_oe == 4'h0, "R10 zero length done",
                {done, active, dat_oe}, 6'b100000);
            return;
        end
        nblk = (len + bsz - 1) / bsz;
        oe_exp = w ? 4'hF : 4'h1;
        for (int b = 0; b < nblk; b++) begin
            chk(dat_oe == oe_exp && (dat_out & oe_exp) == 4'h0 && active,
                "R2 start slot", {dat_oe, dat_out}, {oe_exp, 4'h0});
            for (int i = 0; i < 4; i++) crc_m[i] = '0;
            bad = 0; act_v = 0; exp_v = 0;
            for (int k = 0; k < bsz; k++) begin
                logic [7:0] e;
                int ix;
                ix = b * bsz + k;
                e = (ix < len) ? mem[ix] : 8'h00;
                if (w) begin
                    for (int h = 0; h < 2; h++) begin
                        logic [3:0] nb;
                        @(negedge clk);
                        nb = (h == 0) ? e[7:4] : e[3:0];
                        if ((dat_out !== nb || dat_oe !== 4'hF) && !bad) begin
                            bad = 1; act_v = dat_out; exp_v = nb;
                        end
                        for (int i = 0; i < 4; i++) crc_m[i] = crc_step(crc_m[i], nb[i]);
                    end
                end else begin
                    for (int bi = 7; bi >= 0; bi--) begin
                        @(negedge clk);
                        if ((dat_out[0] !== e[bi] || dat_oe !== 4'h1) && !bad) begin
                            bad = 1; act_v = dat_out[0]; exp_v = e[bi];
                        end
                        crc_m[0] = crc_step(crc_m[0], e[bi]);
                    end
                end
            end
            chk(!bad, (b * bsz + bsz > len) ? "R3 R9 payload with zero pad" : "R3 payload order",
                act_v, exp_v);
            bad = 0; act_v = 0; exp_v = 0;
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                for (int i = 0; i < 4; i++) begin
                    if (oe_exp[i] && dat_out[i] !== crc_m[i][15-c] && !bad) begin
                        bad = 1; act_v = crc_m[i]; exp_v = c;
                    end
                end
            end
            chk(!bad, "R4 per-line crc16", act_v, exp_v);
            @(negedge clk);
            chk(dat_oe == oe_exp && (dat_out & oe_exp) == oe_exp, "R5 end slot",
                {dat_oe, dat_out}, {oe_exp, oe_exp});
            @(negedge clk);
            dat0_in = 1'b1;
            chk(dat_oe == 4'h0, "R5 lines released", dat_oe, 0);
            t = (b == tb_blk) ? tk : 3'b010;
            @(negedge clk); dat0_in = t[2];
            @(negedge clk); dat0_in = t[1];
            @(negedge clk); dat0_in = t[0];
            @(negedge clk); dat0_in = 1'b1;
            if (t != 3'b010) begin
                int used, exp_used;
                @(negedge clk);
                chk(crc_err && !active && !done, "R6 token rejects block",
                    {crc_err, active}, 2'b10);
                repeat (6) @(negedge clk);
                used = sidx - base;
                exp_used = ((b + 1) * bsz < len) ? (b + 1) * bsz : len;
                chk(used == exp_used && dat_oe == 4'h0, "R6 no further bytes", used, exp_used);
                return;
            end
            bad = 0;
            for (int i = 0; i < busy_n && i < lim; i++) begin
                @(negedge clk);
                dat0_in = 1'b0;
                if (dat_oe != 4'h0 || !active || to_err) bad = 1;
            end
            chk(!bad, "R7 lines released while busy", dat_oe, 0);
            if (busy_n >= lim) begin
                @(negedge clk);
                dat0_in = 1'b1;
                chk(to_err && !active && !done, "R8 busy timeout", {to_err, active}, 2'b10);
                return;
            end
            @(negedge clk);
            dat0_in = 1'b1;
            @(negedge clk);
            if (b == nblk - 1) begin
                chk(done && !active && dat_oe == 4'h0, "R10 done after last block",
                    {done, active}, 2'b10);
                chk(sidx - base == len, "R9 exact byte count taken", sidx - base, len);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dat_oe == 4'h0 && !s_ready && !active && !done && !crc_err && !to_err,
            "R1 reset state", {dat_oe, s_ready, active, done, crc_err, to_err}, 0);
        // R12: a waiting stream is not taken while idle
        cur_len = 4; base = sidx;
        repeat (3) @(negedge clk);
        chk(sidx == base && !s_ready, "R12 no take while idle", sidx - base, 0);
        cur_len = 0;
        // directed corners
        xfer(0, 4, 0, 8, 3'b010, -1, 0);
        xfer(5, 4, 0, 8, 3'b010, -1, 2);
        xfer(5, 3, 1, 8, 3'b010, -1, 0);
        xfer(1, 1, 1, 8, 3'b010, -1, 1);
        xfer(9, 3, 1, 8, 3'b101, 1, 0);
        xfer(6, 2, 0, 8, 3'b111, 0, 0);
        xfer(4, 2, 1, 3, 3'b010, -1, 3);
        xfer(4, 2, 0, 1, 3'b010, -1, 1);
        xfer(8, 4, 1, 16, 3'b010, -1, 15);
        xfer(3, 3, 0, 2, 3'b010, -1, 1);
        // seeded random mix
        for (int n = 0; n < 14; n++) begin
            int len, bsz, bz;
            bit w;
            len = 1 + int'($urandom % 48);
            bsz = 1 + int'($urandom % 16);
            w   = 1'($urandom);
            bz  = int'($urandom % 7);
            xfer(len, bsz, w, 16, 3'b010, -1, bz);
        end
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule